// File: doc/BRIEF.md
# Receive FIFO with Automatic Flow Control

This block sits between a serial receiver and a CPU. It queues each received character with its error flags in a 64-entry first-in first-out store. The CPU sees the oldest entry on its read port without waiting, and pops it with a one-cycle read strobe. A two-bit select picks one of four fill thresholds. Reaching that threshold raises a receive-data-available indication. When automatic flow control is on, reaching it also drives the request-to-send output inactive.

On the transmit side, the block watches the clear-to-send input through a synchronizer. When automatic flow control is on, it withholds permission to start a new character while the remote side reports that it is full. A character already on the line is allowed to finish. Software can turn the FIFO off; the store then behaves as a single holding register with a threshold of one entry. A clear control empties the store in one cycle.

Top module: `rx_fifo_flowctl`

## Requirements
- R1: After reset the fill is 0, the store is empty, the overrun flag and data-available are low, tx_allowed is high, and rts_n is high while rts_en is low.
- R2: Entries leave in arrival order, each with its own error flags, and the oldest is presented on the read port before it is popped. A read strobe while empty changes nothing.
- R3: With the FIFO on, the store holds 64 entries. A write into a full store is dropped and sets a sticky overrun flag. A read and a write in the same cycle on a full store are both accepted.
- R4: trig_sel encodes the threshold as 00 = 1, 01 = 16, 10 = 32, 11 = 56 entries. With the FIFO on, rx_data_avail is high exactly when the fill is at or above the threshold.
- R5: With fifo_en low, the store holds one entry, the threshold is 1 whatever trig_sel says, and any change of fifo_en empties the store.
- R6: The RTS mode depends on rts_en and auto_flow_en. With both high, rts_n is high when the fill is at or above the threshold and low below it. With rts_en high and auto_flow_en low, rts_n is low. With rts_en low, rts_n is high.
- R7: With both rts_en and auto_flow_en high and tx_idle high, tx_allowed goes low on the third clock edge after cts_n goes high, and high again the same way. With automatic flow off, tx_allowed stays high.
- R8: While tx_idle is low, tx_allowed holds its value whatever cts_n does. A blocked start takes effect on the first edge at which tx_idle is high again.
- R9: fifo_clr empties the store and clears overrun on one edge, drops a write in that same cycle, and leaves the threshold in effect unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_wr_en | input | 1 | Receiver pushes a character |
| rx_wr_data | input | DATA_W (8) | Received character |
| rx_wr_err | input | ERR_W (3) | Error flags stored with the character |
| cpu_rd_en | input | 1 | CPU pops the oldest entry |
| cpu_rd_data | output | DATA_W (8) | Oldest character |
| cpu_rd_err | output | ERR_W (3) | Error flags of the oldest character |
| rx_fill | output | $clog2(DEPTH)+1 (7) | Number of stored entries |
| rx_empty | output | 1 | Store holds no entry |
| rx_overrun | output | 1 | Sticky: a write was dropped on a full store |
| rx_data_avail | output | 1 | Fill at or above the active threshold |
| fifo_en | input | 1 | FIFO mode on; off gives a one-entry holding register |
| fifo_clr | input | 1 | Empty the store |
| trig_sel | input | 2 | Threshold select |
| rts_en | input | 1 | Request-to-send enable |
| auto_flow_en | input | 1 | Automatic flow control enable |
| cts_n | input | 1 | Clear-to-send from remote, active low, asynchronous |
| tx_idle | input | 1 | Transmitter is between characters |
| rts_n | output | 1 | Request-to-send to remote, active low |
| tx_allowed | output | 1 | Transmitter may start the next character |

## Verification
The threshold logic is exercised with all four select codes. Each code is tried at one entry below its level and at the level itself, which separates an off-by-one compare from a correct one and shows whether rts_n and data-available move together. The store is filled to capacity, then written once more, then written and read in the same cycle, and finally drained. This tells apart a dropped write, a wrongly accepted one, and a lost entry. The clear-to-send path is probed at the second and third edge after a change, with the transmitter idle and with it in mid-character, which separates a missing synchronizer stage from a gate that ignores character boundaries. The FIFO-off mode is checked with two writes and a maximal threshold select, which separates a one-entry register from a deeper store.

// File: rtl/rxq_pkg.sv
// Shared types and helpers for the receive FIFO with flow control.
// Assumes: trigger levels are passed in as parameters by the user.
package rxq_pkg;

    // How the request-to-send output is driven.
    typedef enum logic [1:0] {
        RTS_HELD_OFF = 2'd0,
        RTS_HELD_ON  = 2'd1,
        RTS_AUTO     = 2'd2
    } rts_mode_e;

    // Map the two-bit threshold select to an entry count.
    function automatic int unsigned trig_pick(
        input logic [1:0]  sel,
        input int unsigned l0,
        input int unsigned l1,
        input int unsigned l2,
        input int unsigned l3
    );
        case (sel)
            2'b00:   return l0;
            2'b01:   return l1;
            2'b10:   return l2;
            default: return l3;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
// Entry store: a circular buffer of DEPTH entries with first-word-fall-through
// read, a fill counter, and a sticky overrun flag.
// Assumes: flush has priority over everything; in single mode the capacity is 1.
module rxq_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    parameter int ERR_W  = 3,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1,
    localparam int ENT_W = DATA_W + ERR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              single,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ERR_W-1:0]  wr_err,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [ERR_W-1:0]  rd_err,
    output logic [CW-1:0]     fill,
    output logic              overrun
);

    logic [ENT_W-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    fill_q;
    logic [CW-1:0]    cap;
    logic             full, empty, rd_ok, wr_ok, ovr_q;

    // Capacity and acceptance of this cycle's read and write.
    always_comb begin
        cap   = single ? CW'(1) : CW'(DEPTH);
        full  = (fill_q >= cap);
        empty = (fill_q == '0);
        rd_ok = rd_en && !empty && !flush;
        wr_ok = wr_en && !flush && (!full || rd_ok);
    end

    // Write the incoming entry into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= {wr_err, wr_data};
    end

    // Advance the write pointer with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)  wr_ptr <= '0;
        else if (wr_ok)       wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    end

    // Advance the read pointer with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)  rd_ptr <= '0;
        else if (rd_ok)       rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end

    // Track the number of stored entries.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)        fill_q <= '0;
        else if (wr_ok && !rd_ok)   fill_q <= fill_q + 1'b1;
        else if (rd_ok && !wr_ok)   fill_q <= fill_q - 1'b1;
    end

    // Latch a dropped write until the store is flushed.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)                 ovr_q <= 1'b0;
        else if (wr_en && full && !rd_ok)    ovr_q <= 1'b1;
    end

    assign {rd_err, rd_data} = mem[rd_ptr];
    assign fill    = fill_q;
    assign overrun = ovr_q;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CW'(DEPTH));

    assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !flush) |=> overrun);

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill == '0 && !overrun));

    assert_single_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (single && !flush) |=> (single |-> fill <= CW'(1)));

endmodule

// File: rtl/rxq_thresh.sv
// Threshold logic: picks the active level, raises data-available, and drives
// request-to-send according to the selected flow mode.
// Assumes: fill is a registered count; outputs are combinational from it.
module rxq_thresh
    import rxq_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int TRIG_L0 = 1,
    parameter int TRIG_L1 = 16,
    parameter int TRIG_L2 = 32,
    parameter int TRIG_L3 = 56,
    localparam int CW     = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] fill,
    input  logic [1:0]    trig_sel,
    input  logic          fifo_on,
    input  logic          rts_en,
    input  logic          auto_flow_en,
    output logic          data_avail,
    output logic          rts_n,
    output logic          flow_on
);

    logic [CW-1:0] level;
    rts_mode_e     mode;

    // Active threshold: selected level in FIFO mode, one entry otherwise.
    always_comb begin
        level = fifo_on ? CW'(trig_pick(trig_sel, TRIG_L0, TRIG_L1, TRIG_L2, TRIG_L3))
                        : CW'(1);
        data_avail = (fill >= level);
    end

    // Decode the request-to-send mode and drive the pin.
    always_comb begin
        if (!rts_en)           mode = RTS_HELD_OFF;
        else if (auto_flow_en) mode = RTS_AUTO;
        else                   mode = RTS_HELD_ON;
        case (mode)
            RTS_HELD_ON: rts_n = 1'b0;
            RTS_AUTO:    rts_n = data_avail;
            default:     rts_n = 1'b1;
        endcase
        flow_on = (mode == RTS_AUTO);
    end

    assert_level_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (level >= CW'(1)) && (level <= CW'(DEPTH)));

    assert_rts_rise_on_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_on && $past(flow_on) && $stable(trig_sel) && $stable(fifo_on) && $rose(rts_n))
        |-> (fill > $past(fill)));

endmodule

// File: rtl/txq_gate.sv
// Transmit gate: synchronizes clear-to-send and grants the next character start
// only at character boundaries.
// Assumes: tx_idle is high between characters; cts_n may be asynchronous.
module txq_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    input  logic flow_on,
    input  logic tx_idle,
    output logic tx_allowed
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   allow_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Single-stage capture of the remote signal.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= cts_n;
            end
        end else begin : g_chain
            // Multi-stage synchronizer chain for the remote signal.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], cts_n};
            end
        end
    endgenerate

    // Update the start grant only between characters.
    always_ff @(posedge clk) begin
        if (!rst_n)       allow_q <= 1'b1;
        else if (tx_idle) allow_q <= !(flow_on && sync_q[SYNC_STAGES-1]);
    end

    assign tx_allowed = allow_q;

    assert_hold_midchar_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_idle |=> $stable(tx_allowed));

    assert_flow_off_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_on && tx_idle) |=> tx_allowed);

endmodule

// File: rtl/rx_fifo_flowctl.sv
// Top: receive FIFO with threshold-driven RTS and CTS-gated transmit start.
// Assumes: a change of fifo_en empties the store, as does fifo_clr.
module rx_fifo_flowctl #(
    parameter int DEPTH       = 64,
    parameter int DATA_W      = 8,
    parameter int ERR_W       = 3,
    parameter int TRIG_L0     = 1,
    parameter int TRIG_L1     = 16,
    parameter int TRIG_L2     = 32,
    parameter int TRIG_L3     = 56,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_wr_en,
    input  logic [DATA_W-1:0] rx_wr_data,
    input  logic [ERR_W-1:0]  rx_wr_err,
    input  logic              cpu_rd_en,
    output logic [DATA_W-1:0] cpu_rd_data,
    output logic [ERR_W-1:0]  cpu_rd_err,
    output logic [CW-1:0]     rx_fill,
    output logic              rx_empty,
    output logic              rx_overrun,
    output logic              rx_data_avail,
    input  logic              fifo_en,
    input  logic              fifo_clr,
    input  logic [1:0]        trig_sel,
    input  logic              rts_en,
    input  logic              auto_flow_en,
    input  logic              cts_n,
    input  logic              tx_idle,
    output logic              rts_n,
    output logic              tx_allowed
);

    logic en_q, flush, flow_on;

    // Remember the previous FIFO mode to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fifo_en;
    end

    assign flush    = fifo_clr || (fifo_en != en_q);
    assign rx_empty = (rx_fill == '0);

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ERR_W(ERR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .single  (!fifo_en),
        .wr_en   (rx_wr_en),
        .wr_data (rx_wr_data),
        .wr_err  (rx_wr_err),
        .rd_en   (cpu_rd_en),
        .rd_data (cpu_rd_data),
        .rd_err  (cpu_rd_err),
        .fill    (rx_fill),
        .overrun (rx_overrun)
    );

    rxq_thresh #(.DEPTH(DEPTH), .TRIG_L0(TRIG_L0), .TRIG_L1(TRIG_L1),
                 .TRIG_L2(TRIG_L2), .TRIG_L3(TRIG_L3)) u_thresh (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill         (rx_fill),
        .trig_sel     (trig_sel),
        .fifo_on      (fifo_en),
        .rts_en       (rts_en),
        .auto_flow_en (auto_flow_en),
        .data_avail   (rx_data_avail),
        .rts_n        (rts_n),
        .flow_on      (flow_on)
    );

    txq_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cts_n      (cts_n),
        .flow_on    (flow_on),
        .tx_idle    (tx_idle),
        .tx_allowed (tx_allowed)
    );

endmodule

// File: tb/tb_rx_fifo_flowctl.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_rx_fifo_flowctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_wr_en = 1'b0;
    logic [7:0] rx_wr_data = '0;
    logic [2:0] rx_wr_err = '0;
    logic       cpu_rd_en = 1'b0;
    logic [7:0] cpu_rd_data;
    logic [2:0] cpu_rd_err;
    logic [6:0] rx_fill;
    logic       rx_empty, rx_overrun, rx_data_avail;
    logic       fifo_en = 1'b1;
    logic       fifo_clr = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic       rts_en = 1'b0;
    logic       auto_flow_en = 1'b0;
    logic       cts_n = 1'b0;
    logic       tx_idle = 1'b1;
    logic       rts_n, tx_allowed;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rx_fifo_flowctl dut (
        .clk(clk), .rst_n(rst_n),
        .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data), .rx_wr_err(rx_wr_err),
        .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data), .cpu_rd_err(cpu_rd_err),
        .rx_fill(rx_fill), .rx_empty(rx_empty), .rx_overrun(rx_overrun),
        .rx_data_avail(rx_data_avail), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
        .trig_sel(trig_sel), .rts_en(rts_en), .auto_flow_en(auto_flow_en),
        .cts_n(cts_n), .tx_idle(tx_idle), .rts_n(rts_n), .tx_allowed(tx_allowed)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] e);
        rx_wr_en = 1'b1; rx_wr_data = d; rx_wr_err = e;
        @(negedge clk);
        rx_wr_en = 1'b0;
    endtask

    task automatic pop();
        cpu_rd_en = 1'b1;
        @(negedge clk);
        cpu_rd_en = 1'b0;
    endtask

    task automatic clear();
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 fill", rx_fill, 0);
        chk("R1 empty", rx_empty, 1);
        chk("R1 overrun", rx_overrun, 0);
        chk("R1 avail", rx_data_avail, 0);
        chk("R1 tx_allowed", tx_allowed, 1);
        chk("R1 rts_n", rts_n, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_order();
        pop();
        chk("R2 empty read ignored", rx_fill, 0);
        push(8'h3C, 3'd1);
        push(8'hA5, 3'd4);
        push(8'h0F, 3'd2);
        chk("R2 fill", rx_fill, 3);
        chk("R2 head data", cpu_rd_data, 8'h3C);
        chk("R2 head err", cpu_rd_err, 1);
        pop();
        chk("R2 second data", cpu_rd_data, 8'hA5);
        chk("R2 second err", cpu_rd_err, 4);
        pop();
        chk("R2 third data", cpu_rd_data, 8'h0F);
        chk("R2 third err", cpu_rd_err, 2);
        pop();
        chk("R2 drained", rx_empty, 1);
    endtask

    task automatic t_full();
        clear();
        for (int i = 0; i < 64; i++) push(8'(i), 3'(i));
        chk("R3 full fill", rx_fill, 64);
        chk("R3 no overrun yet", rx_overrun, 0);
        push(8'hAA, 3'd7);
        chk("R3 dropped write fill", rx_fill, 64);
        chk("R3 overrun set", rx_overrun, 1);
        rx_wr_en = 1'b1; rx_wr_data = 8'h55; rx_wr_err = 3'd5; cpu_rd_en = 1'b1;
        @(negedge clk);
        rx_wr_en = 1'b0; cpu_rd_en = 1'b0;
        chk("R3 rd+wr when full fill", rx_fill, 64);
        for (int i = 1; i < 64; i++) begin
            chk("R3 drain order", cpu_rd_data, i);
            pop();
        end
        chk("R3 last entry data", cpu_rd_data, 8'h55);
        chk("R3 last entry err", cpu_rd_err, 5);
        chk("R3 overrun sticky", rx_overrun, 1);
        clear();
        chk("R9 clear drops overrun", rx_overrun, 0);
    endtask

    task automatic t_triggers();
        int lv [4] = '{1, 16, 32, 56};
        rts_en = 1'b1; auto_flow_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            clear();
            for (int i = 0; i < lv[s] - 1; i++) push(8'(i), 3'd0);
            chk("R4 below level avail", rx_data_avail, 0);
            chk("R6 below level rts_n", rts_n, 0);
            push(8'hEE, 3'd0);
            chk("R4 at level avail", rx_data_avail, 1);
            chk("R6 at level rts_n", rts_n, 1);
            pop();
            chk("R6 falls below rts_n", rts_n, 0);
        end
        auto_flow_en = 1'b0;
        #1 chk("R6 manual on rts_n", rts_n, 0);
        rts_en = 1'b0;
        #1 chk("R6 disabled rts_n", rts_n, 1);
        @(negedge clk);
        clear();
        trig_sel = 2'b00;
    endtask

    task automatic t_nofifo();
        fifo_en = 1'b0;
        trig_sel = 2'b11;
        @(negedge clk);
        push(8'h11, 3'd3);
        chk("R5 one entry fill", rx_fill, 1);
        chk("R5 threshold one", rx_data_avail, 1);
        push(8'h22, 3'd0);
        chk("R5 capacity one", rx_fill, 1);
        chk("R5 overrun", rx_overrun, 1);
        chk("R5 kept first", cpu_rd_data, 8'h11);
        fifo_en = 1'b1;
        @(negedge clk);
        chk("R5 mode change empties", rx_fill, 0);
        trig_sel = 2'b00;
    endtask

    task automatic t_cts();
        rts_en = 1'b1; auto_flow_en = 1'b1; tx_idle = 1'b1; cts_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 clear-to-send allowed", tx_allowed, 1);
        cts_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 second edge still allowed", tx_allowed, 1);
        @(negedge clk);
        chk("R7 third edge blocked", tx_allowed, 0);
        cts_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 released", tx_allowed, 1);
        auto_flow_en = 1'b0; cts_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 flow off ignores cts", tx_allowed, 1);
        cts_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_midchar();
        rts_en = 1'b1; auto_flow_en = 1'b1; cts_n = 1'b0; tx_idle = 1'b1;
        repeat (4) @(negedge clk);
        tx_idle = 1'b0; cts_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 held mid-character", tx_allowed, 1);
        tx_idle = 1'b1;
        @(negedge clk);
        chk("R8 blocked at boundary", tx_allowed, 0);
        cts_n = 1'b0; rts_en = 1'b0; auto_flow_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_clear();
        trig_sel = 2'b10;
        clear();
        for (int i = 0; i < 5; i++) push(8'(i), 3'd0);
        fifo_clr = 1'b1; rx_wr_en = 1'b1; rx_wr_data = 8'h77;
        @(negedge clk);
        fifo_clr = 1'b0; rx_wr_en = 1'b0;
        chk("R9 one-cycle clear with write", rx_fill, 0);
        for (int i = 0; i < 31; i++) push(8'(i), 3'd0);
        chk("R9 threshold kept below", rx_data_avail, 0);
        push(8'h31, 3'd0);
        chk("R9 threshold kept at 32", rx_data_avail, 1);
        clear();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_order();
        t_full();
        t_triggers();
        t_nofifo();
        t_cts();
        t_midchar();
        t_clear();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule